// File: doc/BRIEF.md
# Dual Byte FIFO with Selectable DMA Request Thresholds

This block sits between a register interface and a two-wire serial shifter. It holds bytes going out in a transmit queue and bytes coming in from the bus in a receive queue. Software, or a DMA engine acting for it, pushes transmit bytes and pops receive bytes one at a time. The shifter pops transmit bytes and pushes receive bytes from the other side. Each direction drives a ready flag that can serve as a DMA request line. A mode write sets, for each direction, how many entries must be free (transmit) or filled (receive) before the flag rises.

After any reset the block starts in holding-register mode, where each direction stores one byte. Deep FIFO operation is switched on by an enable command. The enable takes effect only when it comes in the cycle right after a software reset, so queue depth cannot change while data is in flight. A flush command empties the transmit side at once. A lock input stops the shifter from taking transmit bytes, for example after the far end refused a byte. Transmit pushes into a full queue are dropped and set a sticky overflow flag. Receive pops from an empty queue leave the read data unchanged and raise no flag.

Top module: `serial_fifo_pair`

## Requirements
- R1: After `rst`, or on the edge where `soft_rst_i` is high, both queues are empty, deep mode is off, both threshold codes are 0, `tx_ovf_o` is 0 and both data outputs are 0. So `tx_rdy_o`=1, `rx_rdy_o`=0, `rx_level_o`=0 and `sh_tx_avail_o`=0.
- R2: `fifo_en_cmd_i` turns deep mode on only when it is sampled on the edge directly after an edge that sampled `soft_rst_i` high. At any other time it has no effect.
- R3: While deep mode is off, each direction holds at most one byte, and both thresholds act as one entry whatever their codes.
- R4: While deep mode is on, each direction holds up to DEPTH (16) bytes and returns them in push order.
- R5: A mode write (`mode_we_i`) stores a 2-bit code per direction, used from the next cycle. Code 0 means one entry, 1 means two, 2 means four, and 3 means one. `tx_rdy_o` is high when (capacity − stored transmit bytes) ≥ threshold. `rx_rdy_o` is high when the number of stored receive bytes ≥ threshold.
- R6: `rx_level_o` equals the number of stored receive bytes and reflects a push or pop from the edge on which it happens.
- R7: On an edge with `rx_pop_i` high and the receive queue not empty, `rx_data_o` loads the oldest byte, which is then removed. A pop of an empty queue leaves `rx_data_o` unchanged and sets no flag.
- R8: A transmit push while the queue is at capacity is dropped and sets `tx_ovf_o`, which stays high until a reset. A shifter push into a full receive queue is dropped.
- R9: `tx_flush_i` empties the transmit queue on the edge it is sampled. It overrides a push and a shifter pop on the same edge, and it sets no overflow.
- R10: While `lock_i` is high, `sh_tx_avail_o` is 0 and shifter pops are ignored, so stored transmit bytes are kept.
- R11: On an edge with `sh_tx_pop_i` high and `sh_tx_avail_o` high, `sh_tx_data_o` loads the oldest transmit byte, which is then removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Software reset command; clears state and arms the enable window |
| fifo_en_cmd_i | input | 1 | Deep-mode enable command |
| mode_we_i | input | 1 | Threshold mode write strobe |
| tx_thr_sel_i | input | 2 | Transmit threshold code |
| rx_thr_sel_i | input | 2 | Receive threshold code |
| tx_flush_i | input | 1 | Transmit flush command |
| tx_push_i | input | 1 | Register-side transmit byte write |
| tx_data_i | input | 8 | Transmit byte |
| rx_pop_i | input | 1 | Register-side receive byte read |
| rx_data_o | output | 8 | Last popped receive byte |
| rx_level_o | output | 5 | Stored receive byte count |
| tx_rdy_o | output | 1 | Transmit request flag |
| rx_rdy_o | output | 1 | Receive request flag |
| tx_ovf_o | output | 1 | Sticky transmit overflow flag |
| lock_i | input | 1 | Blocks transmit bytes from the shifter |
| sh_tx_pop_i | input | 1 | Shifter takes a transmit byte |
| sh_tx_avail_o | output | 1 | A transmit byte is available to the shifter |
| sh_tx_data_o | output | 8 | Last byte taken by the shifter |
| sh_rx_push_i | input | 1 | Shifter delivers a receive byte |
| sh_rx_data_i | input | 8 | Received byte |

## Verification
On every cycle, the assertions check that the stored count never exceeds the capacity of the current mode, that a flush leaves the queue empty, that an empty pop holds the read data, and that deep mode only rises two edges after a software reset. They also check that the overflow flag stays set, that a locked shifter pop removes nothing, and that the receive flag never rises on an empty queue. Only the bench's scenarios can show the data ordering through 16 entries, the exact threshold boundary for each code in both modes, and that an enable outside the window is ignored. The same holds for flush priority over a push on the same edge. A behavioural queue model compared on every clock covers these, along with a long mixed random run.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic [1:0] {
    THR_ONE  = 2'd0,
    THR_TWO  = 2'd1,
    THR_FOUR = 2'd2,
    THR_RSVD = 2'd3
  } thr_code_e;

  // Entries needed for a ready flag; holding-register mode always uses one.
  function automatic logic [3:0] thr_entries(input logic [1:0] code, input logic deep_on);
    logic [3:0] n;
    if (!deep_on) n = 4'd1;
    else begin
      case (thr_code_e'(code))
        THR_TWO:  n = 4'd2;
        THR_FOUR: n = 4'd4;
        default:  n = 4'd1;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/sfp_enable_ctrl.sv
module sfp_enable_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       en_cmd,
  input  logic       mode_we,
  input  logic [1:0] tx_sel_in,
  input  logic [1:0] rx_sel_in,
  output logic       deep_on,
  output logic [1:0] tx_sel,
  output logic [1:0] rx_sel
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      deep_on <= 1'b0;
      tx_sel  <= 2'd0;
      rx_sel  <= 2'd0;
    end else if (soft_rst) begin
      armed   <= 1'b1;
      deep_on <= 1'b0;
      tx_sel  <= 2'd0;
      rx_sel  <= 2'd0;
    end else begin
      armed <= 1'b0;
      if (en_cmd && armed) deep_on <= 1'b1;
      if (mode_we) begin
        tx_sel <= tx_sel_in;
        rx_sel <= rx_sel_in;
      end
    end
  end

  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(deep_on) |-> $past(soft_rst, 2));

endmodule

// File: rtl/sfp_byte_fifo.sv
module sfp_byte_fifo #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_mode,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          push_drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic [LW-1:0] cap;
  logic          do_push, do_pop;

  assign cap       = hold_mode ? LW'(1) : LW'(DEPTH);
  assign do_push   = push && !flush && (count < cap);
  assign do_pop    = pop && !flush && (count != '0);
  assign push_drop = push && !flush && (count >= cap);
  assign level     = count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Storage array: write-only port, no reset, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (do_push && !rst) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_pop) begin
        dout   <= mem[rd_ptr];
        rd_ptr <= bump(rd_ptr);
      end
      if (do_push) wr_ptr <= bump(wr_ptr);
      count <= count + LW'(do_push) - LW'(do_pop);
    end
  end

  // R3 R4
  cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= cap);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> $stable(dout));

endmodule

// File: rtl/sfp_ready_flag.sv
module sfp_ready_flag #(
  parameter  int DEPTH = 16,
  parameter  bit IS_TX = 1'b1,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic [LW-1:0] level,
  input  logic          hold_mode,
  input  logic [1:0]    code,
  output logic          flag
);
  import sfp_pkg::*;

  logic [LW-1:0] need;
  logic [LW-1:0] cap;

  assign need = LW'(thr_entries(code, !hold_mode));
  assign cap  = hold_mode ? LW'(1) : LW'(DEPTH);

  generate
    if (IS_TX) begin : g_free
      assign flag = (cap - level) >= need;
    end else begin : g_fill
      assign flag = level >= need;
    end
  endgenerate

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst_i,
  input  logic          fifo_en_cmd_i,
  input  logic          mode_we_i,
  input  logic [1:0]    tx_thr_sel_i,
  input  logic [1:0]    rx_thr_sel_i,
  input  logic          tx_flush_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [LW-1:0] rx_level_o,
  output logic          tx_rdy_o,
  output logic          rx_rdy_o,
  output logic          tx_ovf_o,
  input  logic          lock_i,
  input  logic          sh_tx_pop_i,
  output logic          sh_tx_avail_o,
  output logic [DW-1:0] sh_tx_data_o,
  input  logic          sh_rx_push_i,
  input  logic [DW-1:0] sh_rx_data_i
);

  logic          clr_all;
  logic          deep_on, hold_mode;
  logic [1:0]    tx_sel, rx_sel;
  logic [LW-1:0] tx_level;
  logic          tx_drop, rx_drop_unused;
  logic          sh_pop_ok;

  assign clr_all   = rst | soft_rst_i;
  assign hold_mode = !deep_on;
  assign sh_pop_ok = sh_tx_pop_i && !lock_i;

  sfp_enable_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst_i),
    .en_cmd    (fifo_en_cmd_i),
    .mode_we   (mode_we_i),
    .tx_sel_in (tx_thr_sel_i),
    .rx_sel_in (rx_thr_sel_i),
    .deep_on   (deep_on),
    .tx_sel    (tx_sel),
    .rx_sel    (rx_sel)
  );

  sfp_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk       (clk),
    .rst       (clr_all),
    .hold_mode (hold_mode),
    .flush     (tx_flush_i),
    .push      (tx_push_i),
    .din       (tx_data_i),
    .pop       (sh_pop_ok),
    .dout      (sh_tx_data_o),
    .level     (tx_level),
    .push_drop (tx_drop)
  );

  sfp_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk       (clk),
    .rst       (clr_all),
    .hold_mode (hold_mode),
    .flush     (1'b0),
    .push      (sh_rx_push_i),
    .din       (sh_rx_data_i),
    .pop       (rx_pop_i),
    .dout      (rx_data_o),
    .level     (rx_level_o),
    .push_drop (rx_drop_unused)
  );

  sfp_ready_flag #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_txflag (
    .level     (tx_level),
    .hold_mode (hold_mode),
    .code      (tx_sel),
    .flag      (tx_rdy_o)
  );

  sfp_ready_flag #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rxflag (
    .level     (rx_level_o),
    .hold_mode (hold_mode),
    .code      (rx_sel),
    .flag      (rx_rdy_o)
  );

  assign sh_tx_avail_o = (tx_level != '0) && !lock_i;

  always_ff @(posedge clk) begin
    if (clr_all) tx_ovf_o <= 1'b0;
    else if (tx_drop) tx_ovf_o <= 1'b1;
  end

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (clr_all)
    (lock_i && sh_tx_pop_i && !tx_flush_i && !tx_push_i && !soft_rst_i)
      |=> (tx_level == $past(tx_level)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf_o && !soft_rst_i) |=> tx_ovf_o);

  // R5
  rx_flag_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rx_rdy_o |-> (rx_level_o != '0));

endmodule

// File: tb/tb_serial_fifo_pair.sv
module tb_serial_fifo_pair;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, soft_rst, fen, mode_we, flush, push, rx_pop, lock, sh_pop, sh_push;
  logic [1:0] tsel, rsel;
  logic [7:0] tdata, shdata, rx_data, sh_data;
  logic [4:0] rx_level;
  logic tx_rdy, rx_rdy, ovf, avail;

  serial_fifo_pair dut (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .fifo_en_cmd_i(fen),
    .mode_we_i(mode_we), .tx_thr_sel_i(tsel), .rx_thr_sel_i(rsel),
    .tx_flush_i(flush), .tx_push_i(push), .tx_data_i(tdata),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_level_o(rx_level),
    .tx_rdy_o(tx_rdy), .rx_rdy_o(rx_rdy), .tx_ovf_o(ovf), .lock_i(lock),
    .sh_tx_pop_i(sh_pop), .sh_tx_avail_o(avail), .sh_tx_data_o(sh_data),
    .sh_rx_push_i(sh_push), .sh_rx_data_i(shdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] txq[$], rxq[$];
  bit m_en, m_armed, m_ovf;
  int m_txc, m_rxc;
  logic [7:0] m_rxd, m_shd;

  function automatic int cap();
    return m_en ? DEPTH : 1;
  endfunction

  function automatic int thr(int code);
    if (!m_en) return 1;
    case (code)
      1: return 2;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic model_clear(bit arm);
    txq.delete(); rxq.delete();
    m_en = 0; m_armed = arm; m_ovf = 0; m_txc = 0; m_rxc = 0;
    m_rxd = 0; m_shd = 0;
  endtask

  always @(posedge clk) begin
    int ocap, tsz, rsz;
    if (rst) model_clear(0);
    else if (soft_rst) model_clear(1);
    else begin
      ocap = cap();
      if (fen && m_armed) m_en = 1;
      m_armed = 0;
      if (mode_we) begin m_txc = tsel; m_rxc = rsel; end
      if (flush) txq.delete();
      else begin
        tsz = txq.size();
        if (sh_pop && !lock && tsz > 0) m_shd = txq.pop_front();
        if (push) begin
          if (tsz < ocap) txq.push_back(tdata);
          else m_ovf = 1;
        end
      end
      rsz = rxq.size();
      if (rx_pop && rsz > 0) m_rxd = rxq.pop_front();
      if (sh_push && rsz < ocap) rxq.push_back(shdata);
    end
    #2;
    if (!rst && !done) begin
      check("R5 tx_rdy", int'(tx_rdy), int'((cap() - txq.size()) >= thr(m_txc)));
      check("R5 rx_rdy", int'(rx_rdy), int'(rxq.size() >= thr(m_rxc)));
      check("R6 rx_level", int'(rx_level), rxq.size());
      check("R7 rx_data", int'(rx_data), int'(m_rxd));
      check("R11 sh_tx_data", int'(sh_data), int'(m_shd));
      check("R10 sh_tx_avail", int'(avail), int'(txq.size() > 0 && !lock));
      check("R8 tx_ovf", int'(ovf), int'(m_ovf));
    end
  end

  task automatic idle();
    soft_rst = 0; fen = 0; mode_we = 0; flush = 0; push = 0; rx_pop = 0;
    sh_pop = 0; sh_push = 0; tdata = 0; shdata = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual 0 expected 1 (run completion)");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(); lock = 0; tsel = 0; rsel = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0; tick();
    // R1 reset state
    check("R1 tx_rdy", int'(tx_rdy), 1);
    check("R1 rx_rdy", int'(rx_rdy), 0);
    check("R1 rx_level", int'(rx_level), 0);
    check("R1 tx_ovf", int'(ovf), 0);
    check("R1 avail", int'(avail), 0);

    // R3 holding-register mode: one byte per direction
    push = 1; tdata = 8'hA1; tick();
    check("R3 tx_rdy full", int'(tx_rdy), 0);
    push = 1; tdata = 8'hA2; tick();
    check("R3 R8 second push dropped", int'(ovf), 1);
    sh_pop = 1; tick();
    check("R11 shifter byte", int'(sh_data), 8'hA1);
    check("R3 tx empty after one pop", int'(avail), 0);
    sh_push = 1; shdata = 8'h11; tick();
    sh_push = 1; shdata = 8'h22; tick();
    check("R3 rx holds one", int'(rx_level), 1);
    rx_pop = 1; tick();
    check("R7 rx byte", int'(rx_data), 8'h11);
    rx_pop = 1; tick();
    check("R7 empty pop keeps data", int'(rx_data), 8'h11);
    check("R7 empty pop no flag", int'(ovf), 1);

    // R2 enable outside the window is ignored
    soft_rst = 1; tick();
    check("R1 soft reset clears ovf", int'(ovf), 0);
    tick();
    fen = 1; tick();
    push = 1; tdata = 8'h01; tick();
    push = 1; tdata = 8'h02; tick();
    check("R2 late enable ignored", int'(ovf), 1);

    // R4 enable in the window, deep operation
    soft_rst = 1; tick();
    fen = 1; tick();
    for (int i = 0; i < DEPTH; i++) begin
      push = 1; tdata = 8'(i + 8'h40); tick();
    end
    check("R4 sixteen stored", int'(ovf), 0);
    check("R4 tx_rdy at full", int'(tx_rdy), 0);
    push = 1; tdata = 8'hEE; tick();
    check("R4 R8 seventeenth dropped", int'(ovf), 1);
    mode_we = 1; tsel = 2; rsel = 2; tick();
    for (int i = 0; i < DEPTH; i++) begin
      sh_pop = 1; tick();
      check("R4 tx order", int'(sh_data), i + 8'h40);
      if (i == 2) check("R5 three free below four", int'(tx_rdy), 0);
      if (i == 3) check("R5 four free", int'(tx_rdy), 1);
    end

    for (int i = 0; i < 20; i++) begin
      sh_push = 1; shdata = 8'(i + 8'h80); tick();
      if (i == 2) check("R5 three stored below four", int'(rx_rdy), 0);
      if (i == 3) check("R5 four stored", int'(rx_rdy), 1);
    end
    check("R6 R8 rx capped", int'(rx_level), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rx_pop = 1; tick();
      check("R4 rx order", int'(rx_data), i + 8'h80);
    end

    // R10 lock
    push = 1; tdata = 8'h5A; tick();
    push = 1; tdata = 8'h5B; tick();
    lock = 1; sh_pop = 1; tick();
    check("R10 avail low while locked", int'(avail), 0);
    sh_pop = 1; tick();
    lock = 0; tick();
    sh_pop = 1; tick();
    check("R10 locked pop kept byte", int'(sh_data), 8'h5A);

    // R9 flush overrides push
    push = 1; tdata = 8'h61; tick();
    flush = 1; push = 1; tdata = 8'h62; tick();
    check("R9 empty after flush", int'(avail), 0);
    check("R9 tx_rdy after flush", int'(tx_rdy), 1);

    // R5 reserved code acts as one entry
    mode_we = 1; tsel = 3; rsel = 3; tick();
    sh_push = 1; shdata = 8'h77; tick();
    check("R5 code3 rx one", int'(rx_rdy), 1);
    rx_pop = 1; tick();

    // Mixed random run compared against the model
    for (int i = 0; i < 3000; i++) begin
      soft_rst = ($urandom_range(0, 80) == 0);
      fen      = ($urandom_range(0, 3) == 0);
      mode_we  = ($urandom_range(0, 9) == 0);
      tsel     = 2'($urandom_range(0, 3));
      rsel     = 2'($urandom_range(0, 3));
      flush    = ($urandom_range(0, 25) == 0);
      push     = ($urandom_range(0, 1) == 0);
      tdata    = 8'($urandom);
      rx_pop   = ($urandom_range(0, 2) == 0);
      lock     = ($urandom_range(0, 5) == 0);
      sh_pop   = ($urandom_range(0, 2) == 0);
      sh_push  = ($urandom_range(0, 1) == 0);
      shdata   = 8'($urandom);
      tick();
    end
    lock = 0;
    tick();
    done = 1;
    summary();
    $finish;
  end

endmodule